// File: doc/BRIEF.md
# Processor Interrupt Level Arbiter

This block gathers fifteen level-sensitive external request lines and a sixteen-bit software-interrupt register into a single pending vector of sixteen priority levels. Each clock it finds the highest pending level and holds a registered trap index for the processor core. The index is an 8-bit code, with an external-interrupt type in the upper nibble and the selected level in the lower nibble. A hard-interrupt request output tells the core that a new external index has been posted. A one-cycle wake pulse tells a sleeping core that a request line has just gone high.

The core shares the held index with the arbiter. When the core takes some other kind of trap, or acknowledges one, it overwrites the index through a load port. The arbiter only replaces an index that is empty or that is already an external-interrupt index, so a trap of a different kind is never disturbed. When nothing is pending and the held index is an external one, the arbiter withdraws it: the index returns to zero and the request drops.

Top module: `irq_level_arb`

## Requirements
- R1: After synchronous reset, trap_idx, hard_irq and wake are 0 and every software-interrupt bit is clear.
- R2: Line ext_req[n] (n = 1..15) and software bit n (n = 1..15) both request level n. Software bit 0 is the timer bit and requests level 14.
- R3: When several levels are pending, trap_idx = {EXT_TYPE, L}, where L is the highest pending level. Level 0 is never signalled. EXT_TYPE defaults to 4'h4, so level 3 gives 8'h43.
- R4: A change on ext_req shows in trap_idx one clock later. A software write shows two clocks later: one clock for the register, then one for the index.
- R5: While the held index is nonzero and its upper nibble is not EXT_TYPE, pending levels leave trap_idx and hard_irq unchanged.
- R6: hard_irq rises only in the clock where a newly computed external index differs from the held one. It stays 1 while that index is held. If the computed index equals the held index, hard_irq is not raised again.
- R7: When no level is pending and the held index has upper nibble EXT_TYPE, trap_idx becomes 0 and hard_irq becomes 0 on the next clock.
- R8: When core_load is high, trap_idx takes core_idx on the next clock and hard_irq drops to 0. This has priority over arbitration in that clock.
- R9: wake is high for exactly one clock following any clock in which some ext_req line went from 0 to 1. A falling line never produces wake.
- R10: A bit of sw_set sets its software bit and a bit of sw_clr clears it. If both are given for the same bit in the same clock, the set wins. A bit with neither keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_req | input | 15 ([15:1]) | External request lines; bit n requests level n |
| sw_set | input | 16 | Set strobes for the software-interrupt bits (bit 0 is the timer bit) |
| sw_clr | input | 16 | Clear strobes for the software-interrupt bits |
| core_load | input | 1 | Core overwrites the held index this clock |
| core_idx | input | 8 | Index value written by the core |
| hard_irq | output | 1 | Hard-interrupt request to the core |
| trap_idx | output | 8 | Held trap index: {type, level} |
| wake | output | 1 | One-clock pulse on a rising external line |

## Verification
The bench targets the following corner cases:
- The timer bit landing on level 14 rather than level 0. A design that got this wrong would post 8'h40 or nothing.
- A foreign trap index that the core loaded. A design without the guard would overwrite it with an external index.
- The core reloading an index equal to the one the arbiter would compute. A design that compares wrongly would raise hard_irq again.
- A set and a clear of the same software bit in one clock. A design where the clear wins would never post that level.
- The withdraw rule, the one- and two-clock latencies, and the absence of a wake pulse on falling lines.

All of these are checked against a behavioural model, both in directed sequences and in a long random phase.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_LOAD  = 2'd1,
    ACT_RAISE = 2'd2,
    ACT_DROP  = 2'd3
  } arb_act_e;
endpackage

// File: rtl/irq_soft_reg.sv
module irq_soft_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] bits_o
);
  logic [W-1:0] bits_q;

  // set has priority over clear on the same bit
  always_ff @(posedge clk) begin
    if (rst) bits_q <= '0;
    else     bits_q <= (bits_q & ~clr_i) | set_i;
  end

  assign bits_o = bits_q;
endmodule

// File: rtl/irq_pend_merge.sv
module irq_pend_merge #(
  parameter int NUM_LVL   = 16,
  parameter int TIMER_LVL = 14
) (
  input  logic [NUM_LVL-1:1] ext_i,
  input  logic [NUM_LVL-1:0] soft_i,
  output logic [NUM_LVL-1:0] pend_o
);
  assign pend_o[0] = 1'b0;

  for (genvar l = 1; l < NUM_LVL; l++) begin : g_lvl
    if (l == TIMER_LVL) begin : g_tmr
      assign pend_o[l] = ext_i[l] | soft_i[l] | soft_i[0];
    end else begin : g_std
      assign pend_o[l] = ext_i[l] | soft_i[l];
    end
  end
endmodule

// File: rtl/irq_pri_scan.sv
module irq_pri_scan #(
  parameter int NUM_LVL = 16,
  parameter int LVL_W   = $clog2(NUM_LVL)
) (
  input  logic [NUM_LVL-1:0] pend_i,
  output logic               any_o,
  output logic [LVL_W-1:0]   lvl_o,
  output logic [NUM_LVL-1:0] grant_o
);
  logic [NUM_LVL:0] above;

  assign above[NUM_LVL] = 1'b0;

  for (genvar l = NUM_LVL - 1; l >= 0; l--) begin : g_chain
    assign above[l]   = above[l+1] | pend_i[l];
    assign grant_o[l] = pend_i[l] & ~above[l+1];
  end

  assign any_o = above[0];

  always_comb begin
    lvl_o = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (grant_o[l]) lvl_o = lvl_o | LVL_W'(l);
    end
  end
endmodule

// File: rtl/irq_index_ctl.sv
module irq_index_ctl
  import irq_arb_pkg::*;
#(
  parameter int              LVL_W    = 4,
  parameter int              TYPE_W   = 4,
  parameter int              IDX_W    = TYPE_W + LVL_W,
  parameter logic [TYPE_W-1:0] EXT_TYPE = 4'h4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             any_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic             core_load_i,
  input  logic [IDX_W-1:0] core_idx_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             irq_o,
  output arb_act_e         act_o
);
  logic [IDX_W-1:0] idx_q;
  logic             irq_q;
  logic [IDX_W-1:0] cand;
  logic             held_ext;
  logic             may_raise;
  arb_act_e         act;

  assign cand      = {EXT_TYPE, lvl_i};
  assign held_ext  = (idx_q[IDX_W-1:LVL_W] == EXT_TYPE);
  assign may_raise = (idx_q == '0) || held_ext;

  always_comb begin
    act = ACT_HOLD;
    if (core_load_i)                         act = ACT_LOAD;
    else if (any_i && may_raise) begin
      if (cand != idx_q)                     act = ACT_RAISE;
    end
    else if (!any_i && held_ext)             act = ACT_DROP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      irq_q <= 1'b0;
    end else begin
      case (act)
        ACT_LOAD: begin
          idx_q <= core_idx_i;
          irq_q <= 1'b0;
        end
        ACT_RAISE: begin
          idx_q <= cand;
          irq_q <= 1'b1;
        end
        ACT_DROP: begin
          idx_q <= '0;
          irq_q <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign idx_o = idx_q;
  assign irq_o = irq_q;
  assign act_o = act;
endmodule

// File: rtl/irq_level_arb.sv
module irq_level_arb
  import irq_arb_pkg::*;
#(
  parameter int                NUM_LVL   = 16,
  parameter int                TIMER_LVL = 14,
  parameter int                TYPE_W    = 4,
  parameter logic [TYPE_W-1:0] EXT_TYPE  = 4'h4,
  localparam int               LVL_W     = $clog2(NUM_LVL),
  localparam int               IDX_W     = TYPE_W + LVL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_LVL-1:1] ext_req,
  input  logic [NUM_LVL-1:0] sw_set,
  input  logic [NUM_LVL-1:0] sw_clr,
  input  logic               core_load,
  input  logic [IDX_W-1:0]   core_idx,
  output logic               hard_irq,
  output logic [IDX_W-1:0]   trap_idx,
  output logic               wake
);
  logic [NUM_LVL-1:0] soft_bits;
  logic [NUM_LVL-1:0] pend_vec;
  logic [NUM_LVL-1:0] grant_vec;
  logic               pend_any;
  logic [LVL_W-1:0]   pend_lvl;
  arb_act_e           arb_act;
  logic [NUM_LVL-1:1] ext_prev;
  logic               wake_q;

  irq_soft_reg #(.W(NUM_LVL)) u_soft (
    .clk    (clk),
    .rst    (rst),
    .set_i  (sw_set),
    .clr_i  (sw_clr),
    .bits_o (soft_bits)
  );

  irq_pend_merge #(.NUM_LVL(NUM_LVL), .TIMER_LVL(TIMER_LVL)) u_merge (
    .ext_i  (ext_req),
    .soft_i (soft_bits),
    .pend_o (pend_vec)
  );

  irq_pri_scan #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_scan (
    .pend_i  (pend_vec),
    .any_o   (pend_any),
    .lvl_o   (pend_lvl),
    .grant_o (grant_vec)
  );

  irq_index_ctl #(
    .LVL_W(LVL_W), .TYPE_W(TYPE_W), .IDX_W(IDX_W), .EXT_TYPE(EXT_TYPE)
  ) u_ctl (
    .clk         (clk),
    .rst         (rst),
    .any_i       (pend_any),
    .lvl_i       (pend_lvl),
    .core_load_i (core_load),
    .core_idx_i  (core_idx),
    .idx_o       (trap_idx),
    .irq_o       (hard_irq),
    .act_o       (arb_act)
  );

  // rising edge on any external line wakes a halted core
  always_ff @(posedge clk) begin
    if (rst) begin
      ext_prev <= '0;
      wake_q   <= 1'b0;
    end else begin
      ext_prev <= ext_req;
      wake_q   <= |(ext_req & ~ext_prev);
    end
  end

  assign wake = wake_q;
endmodule

// File: rtl/irq_level_arb_chk.sv
module irq_level_arb_chk #(
  parameter int                NUM_LVL  = 16,
  parameter int                LVL_W    = 4,
  parameter int                TYPE_W   = 4,
  parameter int                IDX_W    = 8,
  parameter logic [TYPE_W-1:0] EXT_TYPE = 4'h4
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_LVL-1:1] ext_req,
  input logic               core_load,
  input logic [IDX_W-1:0]   core_idx,
  input logic               hard_irq,
  input logic [IDX_W-1:0]   trap_idx,
  input logic               wake,
  input logic [NUM_LVL-1:0] pend,
  input logic [NUM_LVL-1:0] grant
);
  a_r3_single_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  a_r3_grant_is_top: assert property (@(posedge clk) disable iff (rst)
    (pend != '0) |-> ((grant & pend) != '0));

  a_r8_core_load: assert property (@(posedge clk) disable iff (rst)
    core_load |=> (trap_idx == $past(core_idx)) && !hard_irq);

  a_r5_foreign_kept: assert property (@(posedge clk) disable iff (rst)
    (!core_load && trap_idx != '0 && trap_idx[IDX_W-1:LVL_W] != EXT_TYPE)
      |=> $stable(trap_idx) && $stable(hard_irq));

  a_r7_withdraw: assert property (@(posedge clk) disable iff (rst)
    (!core_load && pend == '0 && trap_idx[IDX_W-1:LVL_W] == EXT_TYPE)
      |=> (trap_idx == '0) && !hard_irq);

  a_r6_rise_on_change: assert property (@(posedge clk) disable iff (rst)
    $rose(hard_irq) |-> (trap_idx != $past(trap_idx)));

  a_r9_wake_source: assert property (@(posedge clk) disable iff (rst)
    wake |-> $past(|ext_req));
endmodule

bind irq_level_arb irq_level_arb_chk #(
  .NUM_LVL(NUM_LVL), .LVL_W(LVL_W), .TYPE_W(TYPE_W), .IDX_W(IDX_W), .EXT_TYPE(EXT_TYPE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ext_req   (ext_req),
  .core_load (core_load),
  .core_idx  (core_idx),
  .hard_irq  (hard_irq),
  .trap_idx  (trap_idx),
  .wake      (wake),
  .pend      (pend_vec),
  .grant     (grant_vec)
);

// File: tb/irq_level_arb_bench.sv
`timescale 1ns/1ps
module irq_level_arb_bench;
  localparam logic [3:0] EXT = 4'h4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:1] ext_req = '0;
  logic [15:0] sw_set = '0;
  logic [15:0] sw_clr = '0;
  logic        core_load = 1'b0;
  logic [7:0]  core_idx = '0;
  logic        hard_irq;
  logic [7:0]  trap_idx;
  logic        wake;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  int cyc   = 0;

  always #2.5 clk = ~clk;

  irq_level_arb u_irq_level_arb (
    .clk(clk), .rst(rst), .ext_req(ext_req), .sw_set(sw_set), .sw_clr(sw_clr),
    .core_load(core_load), .core_idx(core_idx),
    .hard_irq(hard_irq), .trap_idx(trap_idx), .wake(wake)
  );

  // behavioural reference
  logic [7:0]  m_idx;
  logic        m_irq;
  logic        m_wake;
  logic [15:0] m_soft;
  logic [15:1] m_prev;

  always @(posedge clk) begin
    if (rst) begin
      m_idx = 0; m_irq = 0; m_wake = 0; m_soft = 0; m_prev = 0;
    end else begin
      int top;
      logic [15:0] p;
      logic [7:0] want;
      p = {ext_req, 1'b0} | (m_soft & 16'hFFFE);
      if (m_soft[0]) p[14] = 1'b1;
      top = 0;
      for (int l = 15; l >= 1; l--) if (p[l] && top == 0) top = l;
      want = {EXT, 4'(top)};
      if (core_load) begin
        m_idx = core_idx; m_irq = 0;
      end else if (p != 0 && (m_idx == 0 || m_idx[7:4] == EXT)) begin
        if (want != m_idx) begin m_idx = want; m_irq = 1; end
      end else if (p == 0 && m_idx[7:4] == EXT) begin
        m_idx = 0; m_irq = 0;
      end
      m_wake = |(ext_req & ~m_prev);
      m_prev = ext_req;
      m_soft = (m_soft & ~sw_clr) | sw_set;
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison with the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R3 R4 model trap_idx", trap_idx, m_idx);
      chk("R6 model hard_irq", hard_irq, m_irq);
      chk("R9 model wake", wake, m_wake);
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sw(logic [15:0] s, logic [15:0] c);
    sw_set = s; sw_clr = c; tick(); sw_set = '0; sw_clr = '0;
  endtask

  task automatic pulse_load(logic [7:0] v);
    core_load = 1'b1; core_idx = v; tick(); core_load = 1'b0; core_idx = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick();
    chk("R1 reset idx", trap_idx, 0);
    chk("R1 reset irq", hard_irq, 0);
    chk("R1 reset wake", wake, 0);

    ext_req[3] = 1'b1; tick();
    chk("R4 ext one-cycle idx", trap_idx, 8'h43);
    chk("R6 raise irq", hard_irq, 1);
    chk("R9 wake on rise", wake, 1);
    tick();
    chk("R9 wake single cycle", wake, 0);

    ext_req[9] = 1'b1; tick();
    chk("R3 highest wins", trap_idx, 8'h49);

    pulse_sw(16'h0001, 16'h0000);
    chk("R4 soft latency not yet", trap_idx, 8'h49);
    tick();
    chk("R2 timer to level 14", trap_idx, 8'h4E);

    ext_req = '0; tick();
    chk("R9 no wake on fall", wake, 0);
    chk("R2 timer holds level 14", trap_idx, 8'h4E);
    pulse_sw(16'h0000, 16'h0001);
    tick();
    chk("R7 withdraw idx", trap_idx, 0);
    chk("R7 withdraw irq", hard_irq, 0);

    pulse_load(8'h11);
    chk("R8 load foreign idx", trap_idx, 8'h11);
    ext_req[15] = 1'b1; tick(3);
    chk("R5 foreign idx kept", trap_idx, 8'h11);
    chk("R5 no irq over foreign", hard_irq, 0);
    pulse_load(8'h00);
    chk("R8 load zero", trap_idx, 0);
    tick();
    chk("R3 level 15 after release", trap_idx, 8'h4F);
    ext_req = '0; tick();
    chk("R7 drop after lines low", trap_idx, 0);

    pulse_sw(16'h0020, 16'h0020);
    tick();
    chk("R10 set wins over clear", trap_idx, 8'h45);
    pulse_sw(16'h0000, 16'h0000);
    chk("R10 bit held", trap_idx, 8'h45);

    pulse_load(8'h45);
    chk("R8 load drops irq", hard_irq, 0);
    tick(2);
    chk("R6 equal index not re-raised", hard_irq, 0);
    chk("R6 equal index kept", trap_idx, 8'h45);
    pulse_sw(16'h0000, 16'h0020);
    tick();
    chk("R7 soft cleared withdraw", trap_idx, 0);

    for (int i = 0; i < 600; i++) begin
      ext_req   = ($urandom_range(0, 3) == 0) ? 15'($urandom) : ext_req;
      sw_set    = ($urandom_range(0, 5) == 0) ? 16'($urandom) & 16'h4421 : '0;
      sw_clr    = ($urandom_range(0, 3) == 0) ? 16'($urandom) : '0;
      core_load = ($urandom_range(0, 9) == 0);
      core_idx  = core_load ? (($urandom_range(0, 1) == 0) ? 8'h00 : 8'($urandom)) : '0;
      tick();
    end
    ext_req = '0; sw_set = '0; sw_clr = '0; core_load = 1'b0;
    tick(3);
    finish_run();
  end
endmodule